// File: doc/BRIEF.md
# Angle-Proportional PWM Encoder

This block turns an absolute angle in the range 0 to 359 into a pulse-width-modulated waveform with a fixed period of 383 step clocks. Every period opens with a 12-step start section and a 4-step zero offset, both high. An angle-dependent high section follows, then a low section. The period closes with an 8-step low exit section. Each angle unit moves one step from the low part of the period to the high part, so a receiver recovers the angle from the high time and the period together. A raised error flag cuts the high pulse to the 12 start steps. A receiver can tell this pulse apart from any valid angle, because a valid angle gives at least 16 high steps.

All logic runs on one system clock. Steps advance on one of two sources. The first is a one-cycle internal tick pulse. The second is the rising edges of an external step clock, which the block synchronizes into the system clock domain. A configuration bit chooses between them. After reset the block stays idle with its output low for four step events of the selected source. The first period starts on the fifth step event. Because of this, an external clock that is already toggling when reset is released cannot produce a partial first period. The angle and the error flag are sampled at the first step of each period and held until the period ends.

Top module: `angle_pwm_encoder`

## Requirements
- R1: Every period, from one rising edge of the output to the next, lasts exactly 383 step events, whatever the angle and the error flag.
- R2: With the error flag low and an angle A in 0..359, the output stays high for 16 + A step events at the start of the period and is low for the remaining 367 - A.
- R3: With the error flag high, the output stays high for exactly 12 step events and is low for the other 371.
- R4: An angle above 359 (360..511) is treated as 359, which gives 375 high steps.
- R5: Angle and error are sampled on the step event that starts a period. Changes to them later in that period have no effect until the next period starts.
- R6: When the select bit is 1, a step event is a rising edge of the external step clock, seen after a two-flop synchronizer. When it is 0, a step event is a cycle with the internal tick high. The source that is not selected has no effect.
- R7: While reset is low, and after reset is released until the first period starts, the output is low. The first step event after release is step event 1, counting only events of the selected source. Step events 1 to 4 only release the block, and the output first rises on step event 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| step_tick_i | input | 1 | Internal step tick, one cycle high per step |
| ext_step_clk_i | input | 1 | External step clock, asynchronous, slower than clk_i / 4 |
| ext_clk_en_i | input | 1 | 1 selects the external step clock, 0 selects the internal tick; kept constant after reset |
| angle_i | input | 9 | Absolute angle, 0..359 valid, larger values clamped |
| angle_err_i | input | 1 | Angle invalid; shortens the high pulse to 12 steps |
| pwm_o | output | 1 | Angle-proportional PWM output |

## Verification
The assertions assume three things about the inputs. The select bit does not change after reset. The external step clock stays high and stays low for at least two system clocks, so the synchronized edge detector produces one-cycle step pulses. The internal tick is a single-cycle pulse. The stimulus meets these conditions with fixed step rates: a tick every 4 system clocks, and an external clock toggling every 3 system clocks. It releases reset only while the external clock is low, so the release count starts on a real edge. Angles and error flags are random across the full 9-bit range, plus the directed values 0, 180, 359, 360 and 511. After each period has been latched the inputs are replaced with unrelated random values, so every measured period also tests the hold rule.

// File: rtl/apwm_pkg.sv
// Package: frame constants shared by the angle PWM encoder.
// Assumes: section lengths are fixed by the output format; the period is
// derived from them so that the high and low parts always add up.
package apwm_pkg;
    localparam int ANGLE_W     = 9;
    localparam int ANGLE_MAX   = 359;
    localparam int INIT_STEPS  = 12;
    localparam int ZERO_STEPS  = 4;
    localparam int EXIT_STEPS  = 8;
    localparam int REL_STEPS   = 4;
    localparam int SYNC_STAGES = 2;
    localparam int PERIOD_STEPS = INIT_STEPS + ZERO_STEPS + ANGLE_MAX + EXIT_STEPS;
    localparam int CNT_W        = $clog2(PERIOD_STEPS);
endpackage

// File: rtl/apwm_step_src.sv
// Module: step source selector.
// Produces a one-cycle step pulse from the internal tick, or from rising edges
// of the external step clock after a synchronizer chain.
// Assumes: the external clock stays at each level for at least two clk_i
// cycles, and ext_sel_i is constant after reset.
module apwm_step_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic ext_clk_i,
    input  logic ext_sel_i,
    output logic step_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sync_q;
    logic            ext_edge;

    // Synchronizer chain plus one history stage for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SH_W-2:0], ext_clk_i};
    end

    // Rising edge seen at the synchronizer output.
    always_comb ext_edge = sync_q[SH_W-2] & ~sync_q[SH_W-1];

    // Source selection.
    always_comb step_o = ext_sel_i ? ext_edge : tick_i;

    // R6: in external mode a step pulse never lasts two cycles.
    a_r6_ext_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ext_sel_i && step_o) |=> !step_o);
endmodule

// File: rtl/apwm_rst_rel.sv
// Module: reset release counter.
// Holds the frame generator idle until REL_STEPS step events of the selected
// source have been seen, so release is aligned to that source.
// Assumes: step_i is already in the clk_i domain.
module apwm_rst_rel #(
    parameter int REL_STEPS = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic step_i,
    output logic run_o
);
    localparam int RC_W = $clog2(REL_STEPS + 1);

    logic [RC_W-1:0] rel_q;

    // Count step events up to the release threshold, then saturate.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                               rel_q <= '0;
        else if (step_i && !run_o)                 rel_q <= rel_q + 1'b1;
    end

    always_comb run_o = (rel_q == RC_W'(REL_STEPS));

    // R7: once released the block stays released until reset.
    a_r7_run_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_o |=> run_o);
endmodule

// File: rtl/apwm_frame.sv
// Module: PWM frame generator.
// Counts step events through a fixed-length period. At the first step of each
// period it latches the high length computed from the angle and error inputs.
// The output is high while the step position is below that length.
// Assumes: step_i is a one-cycle pulse, run_i is sticky after release.
module apwm_frame #(
    parameter int ANGLE_W      = 9,
    parameter int ANGLE_MAX    = 359,
    parameter int INIT_STEPS   = 12,
    parameter int ZERO_STEPS   = 4,
    parameter int PERIOD_STEPS = 383,
    parameter int CNT_W        = 9
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               step_i,
    input  logic               run_i,
    input  logic [ANGLE_W-1:0] angle_i,
    input  logic               err_i,
    output logic               pwm_o
);
    localparam logic [CNT_W-1:0]   LAST_POS = CNT_W'(PERIOD_STEPS - 1);
    localparam logic [ANGLE_W-1:0] ANG_LIM  = ANGLE_W'(ANGLE_MAX);
    localparam logic [CNT_W-1:0]   ERR_LEN  = CNT_W'(INIT_STEPS);
    localparam logic [CNT_W-1:0]   BASE_LEN = CNT_W'(INIT_STEPS + ZERO_STEPS);

    logic               started_q;
    logic [CNT_W-1:0]   pos_q;
    logic [CNT_W-1:0]   hi_len_q;
    logic [ANGLE_W-1:0] ang_clamped;
    logic [CNT_W-1:0]   hi_len_d;
    logic               frame_start;

    // Clamp out-of-range angles and form the high length of the next period.
    always_comb begin
        ang_clamped = (angle_i > ANG_LIM) ? ANG_LIM : angle_i;
        hi_len_d    = err_i ? ERR_LEN : (BASE_LEN + CNT_W'(ang_clamped));
    end

    // A period begins on the first step after release or after the last position.
    always_comb frame_start = step_i && run_i && (!started_q || pos_q == LAST_POS);

    // Step position counter and per-period latch of the high length.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            started_q <= 1'b0;
            pos_q     <= '0;
            hi_len_q  <= ERR_LEN;
        end else if (frame_start) begin
            started_q <= 1'b1;
            pos_q     <= '0;
            hi_len_q  <= hi_len_d;
        end else if (step_i && started_q) begin
            pos_q     <= pos_q + 1'b1;
        end
    end

    // Output level from the current position and the latched length.
    always_comb pwm_o = started_q && (pos_q < hi_len_q);

    // R1: the position never leaves the period.
    a_r1_pos_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pos_q <= LAST_POS);
    // R1: the position only moves on a step event.
    a_r1_pos_moves_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> $stable(pos_q));
    // R2/R3/R4: the latched length stays within the error and full-angle bounds.
    a_r2_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hi_len_q >= ERR_LEN) && (hi_len_q <= BASE_LEN + CNT_W'(ANGLE_MAX)));
    // R5: the length is held everywhere except at a period start.
    a_r5_len_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_start |=> $stable(hi_len_q));
    // R7: no output activity before release.
    a_r7_idle_before_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |-> (!started_q && !pwm_o));
endmodule

// File: rtl/angle_pwm_encoder.sv
// Module: angle-proportional PWM encoder (top).
// Chains the step source selector, the release counter and the frame generator.
// Assumes: ext_clk_en_i is static after reset; angle_i may be any 9-bit value.
module angle_pwm_encoder
    import apwm_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               step_tick_i,
    input  logic               ext_step_clk_i,
    input  logic               ext_clk_en_i,
    input  logic [ANGLE_W-1:0] angle_i,
    input  logic               angle_err_i,
    output logic               pwm_o
);
    logic step;
    logic run;

    apwm_step_src #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_step_src (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (step_tick_i),
        .ext_clk_i (ext_step_clk_i),
        .ext_sel_i (ext_clk_en_i),
        .step_o    (step)
    );

    apwm_rst_rel #(
        .REL_STEPS (REL_STEPS)
    ) u_rst_rel (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (step),
        .run_o  (run)
    );

    apwm_frame #(
        .ANGLE_W      (ANGLE_W),
        .ANGLE_MAX    (ANGLE_MAX),
        .INIT_STEPS   (INIT_STEPS),
        .ZERO_STEPS   (ZERO_STEPS),
        .PERIOD_STEPS (PERIOD_STEPS),
        .CNT_W        (CNT_W)
    ) u_frame (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (step),
        .run_i   (run),
        .angle_i (angle_i),
        .err_i   (angle_err_i),
        .pwm_o   (pwm_o)
    );
endmodule

// File: tb/angle_pwm_encoder_tb_top.sv
// Bench: step sources at fixed rates, directed and seeded random angles,
// expected high time and period computed from the requirements.
module angle_pwm_encoder_tb_top;
    localparam int TICK_DIV = 4;     // internal tick every 4 clocks
    localparam int EXT_DIV  = 6;     // external clock period in clocks
    localparam int PERIOD   = 383;
    localparam int WDOG_NS  = 195000 * 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       ext_clk = 1'b0;
    logic       ext_en = 1'b0;
    logic [8:0] angle = '0;
    logic       err = 1'b0;
    logic       pwm;

    int checks = 0;
    int failures = 0;
    int tick_cnt = 0;
    int ext_cnt = 0;
    int gen_phase = 0;

    always #2.5 clk = ~clk;

    angle_pwm_encoder dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .step_tick_i    (tick),
        .ext_step_clk_i (ext_clk),
        .ext_clk_en_i   (ext_en),
        .angle_i        (angle),
        .angle_err_i    (err),
        .pwm_o          (pwm)
    );

    // Free-running step sources, driven on the falling edge.
    always @(negedge clk) begin
        gen_phase <= gen_phase + 1;
        tick <= ((gen_phase % TICK_DIV) == 0);
        if ((gen_phase % TICK_DIV) == 0) tick_cnt <= tick_cnt + 1;
        ext_clk <= ((gen_phase % EXT_DIV) < 3);
        if ((gen_phase % EXT_DIV) == 0) ext_cnt <= ext_cnt + 1;
    end

    function automatic int exp_high(input int a, input bit e);
        if (e) return 12;
        return 16 + ((a > 359) ? 359 : a);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sample();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_rise();
        while (pwm) sample();
        while (!pwm) sample();
    endtask

    // Reset, release while the external clock is low, count events to first rise.
    task automatic do_reset(input bit use_ext);
        rst_n  = 1'b0;
        ext_en = use_ext;
        repeat (6) sample();
        check("R7 low in reset", int'(pwm), 0);
        while (ext_clk) begin @(posedge clk); #1; end
        @(posedge clk); #1;
        while (ext_clk) begin @(posedge clk); #1; end
        begin
            int base_t;
            int base_e;
            base_t = tick_cnt;
            base_e = ext_cnt;
            rst_n = 1'b1;
            while (!pwm) sample();
            if (use_ext) check("R7/R6 ext events to first rise", ext_cnt - base_e, 5);
            else         check("R7 tick events to first rise", tick_cnt - base_t, 5);
        end
    endtask

    // Apply a stimulus, let it be latched, scramble inputs, measure the period.
    task automatic measure(input int a, input bit e, input int div, input string req);
        int hi;
        int per;
        bit was;
        wait_rise();
        angle = 9'(a);
        err   = e;
        wait_rise();
        angle = 9'($urandom_range(0, 511));
        err   = 1'($urandom_range(0, 1));
        hi = 1; per = 1; was = 1'b1;
        forever begin
            sample();
            if (pwm && !was) break;
            per++;
            if (pwm) hi++;
            was = pwm;
        end
        check(req, hi, div * exp_high(a, e));
        check("R1 period", per, div * PERIOD);
    endtask

    initial begin
        #(WDOG_NS);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        do_reset(1'b0);
        measure(0,   1'b0, TICK_DIV, "R2 angle 0");
        measure(359, 1'b0, TICK_DIV, "R2 angle 359");
        measure(180, 1'b0, TICK_DIV, "R5 angle 180 held");
        measure(200, 1'b1, TICK_DIV, "R3 error pulse");
        measure(360, 1'b0, TICK_DIV, "R4 clamp 360");
        measure(511, 1'b0, TICK_DIV, "R4 clamp 511");
        for (int i = 0; i < 6; i++) begin
            int  ra;
            bit  re;
            ra = $urandom_range(0, 511);
            re = ($urandom_range(0, 3) == 0);
            measure(ra, re, TICK_DIV, re ? "R3 random" : (ra > 359 ? "R4 random" : "R2 random"));
        end
        do_reset(1'b1);
        measure(100, 1'b0, EXT_DIV, "R6 ext angle 100");
        measure(7,   1'b1, EXT_DIV, "R6 ext error");
        measure(450, 1'b0, EXT_DIV, "R6 ext clamp");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule